// File: doc/BRIEF.md
# Edge-Cleared Software Watchdog

This block checks that software is still alive. Software toggles a single watchdog line, and any change of level on that line restarts a tick counter, whichever way the line moves. If the line holds one level for a full timeout window, the block drives its active-low fault output low. The fault stays low until the line changes level again. The timeout is a parameter counted in clock ticks. The counter stops at the limit and never wraps.

The line is asynchronous to the clock. It passes through a flop synchroniser, and then an edge detector compares each synchronised sample with the one before it. Two control inputs come from the system. While the reset-active flag is high, the counter is held at zero and the fault output stays high. While the disable flag is high (it stands for a watchdog line left unconnected), the block is switched off in the same way. Counting starts on the first clock after both flags drop. Wiring the fault output back into a manual-reset path is done outside the block. With that wiring, a stuck line gives a repeating pattern: a timeout, then a reset that clears the fault, then a fresh timeout.

Top module: `wdt_kick_monitor`

## Requirements
- R1: While `srst_i` is high, and on the first cycle after it drops with the line steady, `fault_n_o` is 1.
- R2: With both flags low and no change on `kick_i`, `fault_n_o` becomes 0 exactly TIMEOUT_TICKS rising clock edges after the counting began, and not earlier.
- R3: A low-to-high change on `kick_i` clears the counter on the third rising edge after the change, so `fault_n_o` goes back to 1 there. A fresh full window follows.
- R4: A high-to-low change on `kick_i` has the same clearing effect and the same timing as R3.
- R5: Once low, `fault_n_o` stays 0 while `kick_i` holds its level, for any number of cycles past the timeout (the counter saturates and does not wrap).
- R6: While `sys_rst_active_i` is 1, `fault_n_o` is 1 and the counter is held at zero. Changes on `kick_i` during that time have no effect, and a full window of TIMEOUT_TICKS edges is counted from the release.
- R7: While `wd_disable_i` is 1, `fault_n_o` is 1 and nothing is counted. Once it drops, a full window is counted.
- R8: A pulse on `kick_i` that lasts only one clock period is seen as two level changes, and each of them clears the counter.
- R9: If `kick_i` changes at intervals shorter than the window, `fault_n_o` stays 1 the whole time.
- R10: With the fault fed back as reset-active, a stuck `kick_i` gives repeated faults. Each fault comes exactly TIMEOUT_TICKS edges after the previous reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| srst_i | input | 1 | Synchronous active-high reset of the block |
| kick_i | input | 1 | Asynchronous watchdog line toggled by software |
| sys_rst_active_i | input | 1 | High while the system reset is asserted; holds the counter cleared |
| wd_disable_i | input | 1 | High when the watchdog line is considered floating; switches the watchdog off |
| fault_n_o | output | 1 | Active-low watchdog fault, latched until the next line change |

## Verification
The hardest state to reach from the ports is a saturated counter that then meets a single-cycle pulse. That pulse carries two edges, three clocks apart from the pulse start, and both must clear the counter. The stimulus first drives the block into a fault. It holds the line long past the window, then issues a one-period pulse and times the next fault from the second edge. The feedback loop of R10 is built in the stimulus itself: the bench raises the reset-active flag whenever it sees the fault, and it measures several windows in a row.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Watchdog operating state, derived each cycle from the control flags
    // and the expiry status of the counter.
    typedef enum logic [1:0] {
        WD_HELD     = 2'd0,
        WD_COUNTING = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_mode_e;

    // Status handed from the counter to the top-level output stage.
    typedef struct packed {
        logic expired;
        logic clearing;
    } wd_status_t;

    // Width needed to hold the values 0..limit inclusive.
    function automatic int unsigned wd_cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    // Output encoding: the fault output is low only in the expired state.
    function automatic logic wd_fault_n(input wd_mode_e mode);
        return (mode != WD_EXPIRED);
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (srst_i) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i) begin
                    if (srst_i) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/wdt_edge_det.sv
module wdt_edge_det (
    input  logic clk_i,
    input  logic srst_i,
    input  logic sample_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (srst_i) prev_q <= 1'b0;
        else        prev_q <= sample_i;
    end

    // Either polarity counts as a kick.
    assign edge_o = sample_i ^ prev_q;

    // R8
    edge_flag_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (sample_i != $past(sample_i)) |-> edge_o);

endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 1000
) (
    input  logic       clk_i,
    input  logic       srst_i,
    input  logic       hold_i,
    input  logic       clear_i,
    output wd_status_t status_o
);
    localparam int unsigned     CNT_W = wd_cnt_width(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_limit;

    assign at_limit = (cnt_q == LIMIT);

    always_comb begin
        cnt_d = cnt_q;
        if (hold_i || clear_i)  cnt_d = '0;
        else if (!at_limit)     cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign status_o.expired  = at_limit;
    assign status_o.clearing = clear_i & ~hold_i;

    // R5
    sat_bound_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        cnt_q <= LIMIT);

    // R5
    fault_latch_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (at_limit && !hold_i && !clear_i) |=> at_limit);

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (!hold_i && !clear_i && !at_limit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R6
    held_clear_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        hold_i |=> !at_limit);

endmodule

// File: rtl/wdt_kick_monitor.sv
module wdt_kick_monitor
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 1000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic kick_i,
    input  logic sys_rst_active_i,
    input  logic wd_disable_i,
    output logic fault_n_o
);
    logic       kick_sync;
    logic       kick_edge;
    logic       hold;
    wd_status_t status;
    wd_mode_e   mode;

    assign hold = sys_rst_active_i | wd_disable_i;

    wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .async_i (kick_i),
        .sync_o  (kick_sync)
    );

    wdt_edge_det u_edge (
        .clk_i    (clk_i),
        .srst_i   (srst_i),
        .sample_i (kick_sync),
        .edge_o   (kick_edge)
    );

    wdt_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctr (
        .clk_i    (clk_i),
        .srst_i   (srst_i),
        .hold_i   (hold),
        .clear_i  (kick_edge),
        .status_o (status)
    );

    always_comb begin
        if (hold)                mode = WD_HELD;
        else if (status.expired) mode = WD_EXPIRED;
        else                     mode = WD_COUNTING;
    end

    assign fault_n_o = wd_fault_n(mode);

    // R6
    held_high_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        sys_rst_active_i |-> fault_n_o);

    // R7
    off_high_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        wd_disable_i |-> fault_n_o);

    // R3
    kick_release_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (status.clearing && !sys_rst_active_i && !wd_disable_i) |=>
            (fault_n_o || $past(TIMEOUT_TICKS == 0)));

endmodule

// File: tb/tb_wdt_kick_monitor.sv
module tb_wdt_kick_monitor;
    localparam int unsigned T = 40;

    logic clk = 1'b0;
    logic srst_i = 1'b1;
    logic kick_i = 1'b0;
    logic sys_rst_active_i = 1'b1;
    logic wd_disable_i = 1'b0;
    logic fault_n_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_kick_monitor #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) dut (
        .clk_i            (clk),
        .srst_i           (srst_i),
        .kick_i           (kick_i),
        .sys_rst_active_i (sys_rst_active_i),
        .wd_disable_i     (wd_disable_i),
        .fault_n_o        (fault_n_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_fault(input logic exp, input string req);
        compared++;
        if (fault_n_o !== exp) begin
            mismatched++;
            $display("FAIL %s: fault_n_o actual=%b expected=%b at cycle %0d",
                     req, fault_n_o, exp, cycles);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        srst_i = 1'b1; sys_rst_active_i = 1'b1; kick_i = 1'b0; wd_disable_i = 1'b0;
        tick(3);
        expect_fault(1'b1, "R1");
        srst_i = 1'b0;
        tick(1);
        expect_fault(1'b1, "R1");
    endtask

    // R2: full window after release, fault exactly at T
    task automatic t_timeout();
        sys_rst_active_i = 1'b0;
        tick(T - 1);
        expect_fault(1'b1, "R2");
        tick(1);
        expect_fault(1'b0, "R2");
    endtask

    // R5: stays latched, no wrap
    task automatic t_latched();
        for (int i = 0; i < 3 * T; i++) begin
            tick(1);
            if (i % 10 == 0) expect_fault(1'b0, "R5");
        end
        expect_fault(1'b0, "R5");
    endtask

    // R3 / R4: edge of a given polarity clears on the third edge
    task automatic t_edge(input logic level, input string req);
        kick_i = level;
        tick(2);
        expect_fault(1'b0, req);
        tick(1);
        expect_fault(1'b1, req);
        tick(T - 1);
        expect_fault(1'b1, req);
        tick(1);
        expect_fault(1'b0, req);
    endtask

    // R8: one-period pulse, both edges clear
    task automatic t_pulse();
        logic base;
        base = kick_i;
        kick_i = ~base;
        tick(1);
        kick_i = base;
        tick(2);
        expect_fault(1'b1, "R8");
        tick(T);
        expect_fault(1'b1, "R8");
        tick(1);
        expect_fault(1'b0, "R8");
    endtask

    // R6: reset-active holds, edges ignored, full window from release
    task automatic t_hold_reset();
        sys_rst_active_i = 1'b1;
        tick(1);
        expect_fault(1'b1, "R6");
        for (int i = 0; i < 4; i++) begin
            kick_i = ~kick_i;
            tick(7);
        end
        tick(2 * T);
        expect_fault(1'b1, "R6");
        sys_rst_active_i = 1'b0;
        tick(T - 1);
        expect_fault(1'b1, "R6");
        tick(1);
        expect_fault(1'b0, "R6");
    endtask

    // R7: disable switches the watchdog off
    task automatic t_disable();
        wd_disable_i = 1'b1;
        tick(1);
        expect_fault(1'b1, "R7");
        tick(2 * T);
        expect_fault(1'b1, "R7");
        wd_disable_i = 1'b0;
        tick(T - 1);
        expect_fault(1'b1, "R7");
        tick(1);
        expect_fault(1'b0, "R7");
    endtask

    // R9: frequent kicks keep fault high
    task automatic t_kicked();
        kick_i = ~kick_i;
        tick(3);
        for (int i = 0; i < 5 * T; i++) begin
            if (i % (T / 2) == 0) kick_i = ~kick_i;
            tick(1);
            if (i % 8 == 0) expect_fault(1'b1, "R9");
        end
        expect_fault(1'b1, "R9");
    endtask

    // R10: fault fed back as reset-active gives periodic faults
    task automatic t_feedback();
        sys_rst_active_i = 1'b1;
        tick(5);
        for (int k = 0; k < 3; k++) begin
            sys_rst_active_i = 1'b0;
            tick(T - 1);
            expect_fault(1'b1, "R10");
            tick(1);
            expect_fault(1'b0, "R10");
            sys_rst_active_i = ~fault_n_o;
            tick(1);
            expect_fault(1'b1, "R10");
            tick(8);
        end
        sys_rst_active_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_timeout();
        t_latched();
        t_edge(1'b1, "R3");
        t_edge(1'b0, "R4");
        t_pulse();
        t_hold_reset();
        t_disable();
        t_kicked();
        t_feedback();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule